// File: doc/BRIEF.md
# Watchdog Timer with Sleep Status Flags

This block is a watchdog timer. An 8-bit counter advances on each cycle in which the oscillator tick and the enable are both high. Its carry drives a postscaler whose ratio is picked at run time from divide-by-1 up to divide-by-128. When the postscaler overflows, the block either asks for a chip reset or, if the device is asleep, wakes it.

The block also keeps two active-low status flags. The time-out flag goes low when the watchdog expires. The power-down flag goes low when the device enters sleep. Software restarts the timer with a clear strobe. A sleep strobe restarts the timer and raises a sleep-mode indication, and that indication drives the oscillator shutdown logic elsewhere. The counter, the postscaler and the flags share one state update. A clear or sleep strobe therefore always wins over an expiry in the same cycle.

Top module: `wdog_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `to_n`=1, `pd_n`=1, `asleep`=0, and `reset_req`=0 and `wake_pulse`=0.
- R2: While awake, `reset_req` is high for exactly one cycle. It starts on the clock edge that accepts the (256·2^s)-th counted tick after the last clear or sleep strobe, where s is `ratio_sel`.
- R3: An expiry while awake drives `to_n` to 0 and leaves `pd_n` unchanged.
- R4: A clear strobe restarts the count from zero, sets `to_n`=1 and `pd_n`=1, and sets `asleep`=0.
- R5: A sleep strobe (with clear low) restarts the count from zero and sets `to_n`=1, `pd_n`=0 and `asleep`=1.
- R6: An expiry while `asleep`=1 gives a one-cycle `wake_pulse` and no `reset_req`. It drives `to_n` to 0 and `asleep` to 0, and `pd_n` stays 0.
- R7: The 3-bit `ratio_sel` value s selects a postscaler ratio of 2^s: 0 gives /1, 1 gives /2, and so on up to 7, which gives /128.
- R8: A cycle with `wdt_en`=0 or `osc_tick`=0 is not counted. The count holds rather than clears, and no pulse follows such a cycle.
- R9: A clear or sleep strobe accepted on the same edge as an expiry suppresses that expiry. No pulse is produced, and the strobe takes effect.
- R10: After an expiry the count continues from zero, so expiries repeat every 256·2^s counted ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| osc_tick | input | 1 | Tick enable from the watchdog's free-running oscillator |
| wdt_en | input | 1 | Watchdog enable |
| clr_cmd | input | 1 | Clear-watchdog strobe |
| sleep_cmd | input | 1 | Enter-sleep strobe |
| ratio_sel | input | 3 | Postscaler ratio select, divide by 2^value |
| reset_req | output | 1 | One-cycle chip reset request |
| wake_pulse | output | 1 | One-cycle wake-up event |
| to_n | output | 1 | Time-out flag, low after an expiry |
| pd_n | output | 1 | Power-down flag, low after sleep |
| asleep | output | 1 | Sleep-mode indication |

## Verification
The checker watches every cycle for several relationships. Reset and wake pulses must never overlap and each lasts one cycle. After a clear or sleep strobe the flags must take their required values. A pulse must never follow an uncounted cycle. A reset request must never come out of sleep, and `asleep` must imply `pd_n`=0. Only the bench scenarios can show the exact expiry cycle for each ratio, the extra time added by pauses, a clear partway through a count, and a strobe suppressing an expiry on the same edge. The bench also shows the periodic repeat and the sleep-then-wake-then-reset sequence. It does this by predicting every pulse cycle and matching it against the design's output.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_CLEAR = 2'd1,
    CMD_SLEEP = 2'd2
  } wdog_cmd_e;

  function automatic wdog_cmd_e decode_cmd(input logic clr, input logic slp);
    if (clr)      return CMD_CLEAR;
    else if (slp) return CMD_SLEEP;
    else          return CMD_NONE;
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic step,
  output logic carry
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (step)      cnt_q <= cnt_q + 1'b1;
  end

  // carry out on the tick that wraps the counter
  assign carry = step && (cnt_q == CNT_MAX);
endmodule

// File: rtl/wdog_postscale.sv
module wdog_postscale #(
  parameter int POST_W = 7,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             carry,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  logic [POST_W-1:0] post_q;
  logic [POST_W-1:0] mask;

  // low 'sel' bits participate in the terminal-count match
  always_comb begin
    for (int i = 0; i < POST_W; i++) begin
      mask[i] = (i < int'(sel));
    end
  end

  assign expire = carry && ((post_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart) post_q <= '0;
    else if (expire)    post_q <= '0;
    else if (carry)     post_q <= post_q + 1'b1;
  end
endmodule

// File: rtl/wdog_status.sv
module wdog_status
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic slp,
  input  logic expire,
  output logic reset_req,
  output logic wake_pulse,
  output logic to_n,
  output logic pd_n,
  output logic asleep
);
  wdog_cmd_e cmd;
  assign cmd = decode_cmd(clr, slp);

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_req  <= 1'b0;
      wake_pulse <= 1'b0;
      to_n       <= 1'b1;
      pd_n       <= 1'b1;
      asleep     <= 1'b0;
    end else begin
      reset_req  <= 1'b0;
      wake_pulse <= 1'b0;
      unique case (cmd)
        CMD_CLEAR: begin
          to_n   <= 1'b1;
          pd_n   <= 1'b1;
          asleep <= 1'b0;
        end
        CMD_SLEEP: begin
          to_n   <= 1'b1;
          pd_n   <= 1'b0;
          asleep <= 1'b1;
        end
        default: begin
          if (expire) begin
            to_n <= 1'b0;
            if (asleep) begin
              wake_pulse <= 1'b1;
              asleep     <= 1'b0;
            end else begin
              reset_req  <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W  = 8,
  parameter int POST_W = 7,
  localparam int SEL_W = $clog2(POST_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick,
  input  logic             wdt_en,
  input  logic             clr_cmd,
  input  logic             sleep_cmd,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             reset_req,
  output logic             wake_pulse,
  output logic             to_n,
  output logic             pd_n,
  output logic             asleep
);
  logic restart;
  logic step;
  logic carry;
  logic expire;

  assign restart = clr_cmd || sleep_cmd;
  assign step    = osc_tick && wdt_en;

  wdog_prescale #(.CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .restart(restart), .step(step), .carry(carry)
  );

  wdog_postscale #(.POST_W(POST_W), .SEL_W(SEL_W)) u_post (
    .clk(clk), .rst(rst), .restart(restart), .carry(carry),
    .sel(ratio_sel), .expire(expire)
  );

  wdog_status u_stat (
    .clk(clk), .rst(rst), .clr(clr_cmd), .slp(sleep_cmd), .expire(expire),
    .reset_req(reset_req), .wake_pulse(wake_pulse),
    .to_n(to_n), .pd_n(pd_n), .asleep(asleep)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic clk,
  input logic rst,
  input logic osc_tick,
  input logic wdt_en,
  input logic clr_cmd,
  input logic sleep_cmd,
  input logic reset_req,
  input logic wake_pulse,
  input logic to_n,
  input logic pd_n,
  input logic asleep
);
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(reset_req && wake_pulse));

  a_r2_single_reset: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  a_r6_single_wake: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  a_r4_clear_flags: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> (to_n && pd_n && !asleep && !reset_req && !wake_pulse));

  a_r5_sleep_flags: assert property (@(posedge clk) disable iff (rst)
    (sleep_cmd && !clr_cmd) |=> (to_n && !pd_n && asleep && !reset_req && !wake_pulse));

  a_r8_idle_no_pulse: assert property (@(posedge clk) disable iff (rst)
    (!wdt_en || !osc_tick) |=> (!reset_req && !wake_pulse));

  a_r3_reset_timeout: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (!to_n && !asleep && !$past(asleep)));

  a_r6_wake_state: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (!to_n && !pd_n && !asleep && $past(asleep)));

  a_r5_sleep_pd: assert property (@(posedge clk) disable iff (rst)
    asleep |-> !pd_n);
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk(clk), .rst(rst), .osc_tick(osc_tick), .wdt_en(wdt_en),
  .clr_cmd(clr_cmd), .sleep_cmd(sleep_cmd), .reset_req(reset_req),
  .wake_pulse(wake_pulse), .to_n(to_n), .pd_n(pd_n), .asleep(asleep)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b1;
  logic       wdt_en = 1'b0;
  logic       clr_cmd = 1'b0;
  logic       sleep_cmd = 1'b0;
  logic [2:0] ratio_sel = 3'd0;
  logic       reset_req, wake_pulse, to_n, pd_n, asleep;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    bit    wake;
    string req;
  } evt_t;
  evt_t exp_q[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  wdog_timer u_wdog_timer (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .wdt_en(wdt_en),
    .clr_cmd(clr_cmd), .sleep_cmd(sleep_cmd), .ratio_sel(ratio_sel),
    .reset_req(reset_req), .wake_pulse(wake_pulse),
    .to_n(to_n), .pd_n(pd_n), .asleep(asleep)
  );

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic push(input int at, input bit wake, input string req);
    evt_t e;
    e.at = at; e.wake = wake; e.req = req;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor: every pulse must match the head of the queue
  always @(negedge clk) begin
    if (!rst && (reset_req || wake_pulse)) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL unexpected pulse R2/R9: actual reset=%0d wake=%0d expected none (cycle %0d)",
                 reset_req, wake_pulse, cyc);
      end else begin
        evt_t e;
        e = exp_q.pop_front();
        check({e.req, " pulse cycle"}, cyc, e.at);
        check({e.req, " wake kind"}, int'(wake_pulse), int'(e.wake));
        check({e.req, " reset kind"}, int'(reset_req), int'(!e.wake));
      end
    end
  end

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // clear strobe; returns the edge index that accepted it
  task automatic restart(input logic [2:0] s, output int base);
    @(negedge clk);
    ratio_sel = s; wdt_en = 1'b1; clr_cmd = 1'b1;
    base = cyc + 1;
    @(negedge clk);
    clr_cmd = 1'b0;
  endtask

  task automatic sleep_at(input int c, output int edge_i);
    wait_until(c);
    sleep_cmd = 1'b1;
    edge_i = c + 1;
    @(negedge clk);
    sleep_cmd = 1'b0;
  endtask

  initial begin
    int b, b2, s;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 to_n", int'(to_n), 1);
    check("R1 pd_n", int'(pd_n), 1);
    check("R1 asleep", int'(asleep), 0);
    check("R1 pulses", int'(reset_req | wake_pulse), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 to_n after release", int'(to_n), 1);
    check("R1 pd_n after release", int'(pd_n), 1);

    // R2/R10 ratio 0, two periodic expiries; R3 flags
    restart(3'd0, b);
    push(b + 256, 1'b0, "R2");
    push(b + 512, 1'b0, "R10");
    wait_until(b + 257);
    check("R3 to_n low", int'(to_n), 0);
    check("R3 pd_n kept", int'(pd_n), 1);
    wait_until(b + 520);
    // R4: clear restores flags
    restart(3'd3, b);
    check("R4 to_n", int'(to_n), 1);
    check("R4 pd_n", int'(pd_n), 1);
    // R7 ratio 3 -> /8
    push(b + 2048, 1'b0, "R7 sel3");
    wait_until(b + 2052);
    wdt_en = 1'b0;

    // R4: clear partway through restarts count (ratio 1)
    restart(3'd1, b);
    wait_until(b + 400);
    restart(3'd1, b2);
    push(b2 + 512, 1'b0, "R4 midway");
    wait_until(b2 + 516);
    wdt_en = 1'b0;

    // R8: enable pause 50 edges, tick pause 20 edges
    restart(3'd0, b);
    wait_until(b + 100); wdt_en = 1'b0;
    wait_until(b + 150); wdt_en = 1'b1;
    wait_until(b + 200); osc_tick = 1'b0;
    wait_until(b + 220); osc_tick = 1'b1;
    push(b + 326, 1'b0, "R8 pause");
    wait_until(b + 330);
    wdt_en = 1'b0;

    // R5/R6: sleep then wake then reset (ratio 2)
    restart(3'd2, b);
    sleep_at(b + 300, s);
    check("R5 to_n", int'(to_n), 1);
    check("R5 pd_n", int'(pd_n), 0);
    check("R5 asleep", int'(asleep), 1);
    push(s + 1024, 1'b1, "R6 wake");
    push(s + 2048, 1'b0, "R6 then reset");
    wait_until(s + 1025);
    check("R6 to_n", int'(to_n), 0);
    check("R6 pd_n", int'(pd_n), 0);
    check("R6 asleep", int'(asleep), 0);
    wait_until(s + 2050);
    check("R3 pd_n unchanged", int'(pd_n), 0);
    wdt_en = 1'b0;

    // R9: sleep on the expiry edge suppresses the reset
    restart(3'd0, b);
    check("R4 pd_n restored", int'(pd_n), 1);
    sleep_at(b + 255, s);
    check("R9 asleep", int'(asleep), 1);
    check("R9 to_n", int'(to_n), 1);
    push(s + 256, 1'b1, "R9 wake");
    wait_until(s + 257);
    // clear on the next expiry edge suppresses it too
    wait_until(s + 511);
    clr_cmd = 1'b1;
    @(negedge clk);
    clr_cmd = 1'b0; wdt_en = 1'b0;
    check("R9 clear to_n", int'(to_n), 1);
    repeat (10) @(negedge clk);

    // R7 ratio 7 -> /128
    restart(3'd7, b);
    push(b + 32768, 1'b0, "R7 sel7");
    wait_until(b + 32770);
    wdt_en = 1'b0;
    repeat (5) @(negedge clk);

    check("R2 queue drained", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule